// File: doc/BRIEF.md
# Legacy Two-Port Command Interface

This block is a byte-wide host front end for an older-style secure module that is reached through only two I/O locations. Port 0 carries command bytes written by the host, index bytes for register access and, later, response bytes. Port 1 carries status on read and control codes on write. The host streams a command into an internal buffer one byte at a time. It ends the command either by writing the last-byte control code just before the final byte, or by filling the buffer completely. The block then reports busy while a stub execution engine runs for a fixed number of cycles. After that it offers the response bytes on port 0 with a data-available flag.

Command semantics are not modelled. The stub response is each command byte XORed with a parameter mask, in the original order. The host can also select a 12-bit internal index through the ports and read one byte back. The eight-byte identity sits at an aligned base index: four version bytes followed by a four-character ASCII tag. An abort code discards any transaction in progress and returns the block to idle.

Top module: `legacy_port_front`

## Requirements
- R1: After reset, a port-1 read returns 0x00 and a port-0 read returns 0xFF.
- R2: A port-1 write with bit 7 set stores bits [3:0] as index bits [11:8]. The next port-0 write supplies index bits [7:0] and is not taken as a command byte. Port 1 then returns the indexed byte until a port-1 read strobe consumes it; after that, port 1 returns status again.
- R3: Index ID_BASE+0..+3 returns ID_VERSION byte 0..3, least significant byte first. Index ID_BASE+4..+7 returns the ID_TAG characters in reading order, most significant byte first. Every other index returns 0xFF.
- R4: The status byte on port 1 has bit 0 = busy, bit 1 = data available, bit 2 = retry-error, and bits 7..3 = 0.
- R5: A port-1 write of 0x04 marks the next accepted port-0 command byte as final. Busy is set in the cycle after that byte is written.
- R6: A command that reaches DEPTH bytes ends on its DEPTH-th byte without a mark. Before that byte the block is neither busy nor data-available.
- R7: Busy stays at 1 for exactly EXEC_CYCLES cycles and then changes to data-available.
- R8: Port-0 reads while data is available return command byte i XOR RESP_MASK, for i = 0 upward. Data-available clears after the read of the byte at the command's length.
- R9: A port-1 write of 0x01 aborts the transaction. It clears busy, data-available, the partial command and any pending response, and the block then accepts a new command.
- R10: A port-0 read with no response pending returns 0xFF and sets retry-error. The first command byte of the next command clears retry-error.
- R11: Port-0 writes while busy or while data is available are ignored. They do not change the response length or the response bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| port_sel | input | 1 | 0 selects the data/index port, 1 selects the status/control port |
| bus_wr | input | 1 | Write strobe; one byte per cycle |
| bus_rd | input | 1 | Read strobe; side effects occur at the clock edge; ignored when bus_wr is high |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the selected port, driven combinationally |

## Verification
The assertions check the following on every cycle:
- an abort lands in idle with an empty buffer;
- a port-0 read outside the response phase leaves retry-error set;
- port-0 writes during busy or response leave the length unchanged;
- busy only ever moves on to the response phase;
- a response pointer holds until a read strobe;
- the length never exceeds the buffer depth.

The scenarios alone show the data values: the identity bytes per index, the exact busy duration, the XOR-masked response order, and the automatic end of a full-depth command. They also show that a new command works after aborts in each phase.

// File: rtl/lgp_pkg.sv
package lgp_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RECV = 2'd1,
        ST_BUSY = 2'd2,
        ST_RESP = 2'd3
    } lgp_state_e;

    localparam logic [7:0] CTL_ABORT = 8'h01;
    localparam logic [7:0] CTL_FINAL = 8'h04;
    localparam int         CTL_INDEX_BIT = 7;
    localparam logic [7:0] EMPTY_BYTE = 8'hFF;

endpackage

// File: rtl/lgp_cmd_store.sv
module lgp_cmd_store #(
    parameter int DEPTH = 1024,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [7:0]    wr_byte,
    input  logic [AW-1:0] rd_addr,
    output logic [7:0]    rd_byte
);

    logic [7:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem_q[wr_addr] <= wr_byte;
        end
    end

    assign rd_byte = mem_q[rd_addr];

endmodule

// File: rtl/lgp_exec_stub.sv
module lgp_exec_stub #(
    parameter int EXEC_CYCLES = 16,
    localparam int EXW = $clog2(EXEC_CYCLES + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic abort,
    output logic done
);

    logic [EXW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (abort) begin
            cnt_d = '0;
        end else if (start) begin
            cnt_d = EXW'(EXEC_CYCLES);
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign done = (cnt_q == EXW'(1)) && !abort;

endmodule

// File: rtl/lgp_ident_rom.sv
module lgp_ident_rom #(
    parameter logic [11:0] ID_BASE    = 12'hF00,
    parameter logic [31:0] ID_VERSION = 32'h0B07_0201,
    parameter logic [31:0] ID_TAG     = 32'h5158_5253
) (
    input  logic [11:0] index,
    output logic [7:0]  value
);

    always_comb begin
        value = lgp_pkg::EMPTY_BYTE;
        if (index[11:3] == ID_BASE[11:3]) begin
            case (index[2:0])
                3'd0: value = ID_VERSION[7:0];
                3'd1: value = ID_VERSION[15:8];
                3'd2: value = ID_VERSION[23:16];
                3'd3: value = ID_VERSION[31:24];
                3'd4: value = ID_TAG[31:24];
                3'd5: value = ID_TAG[23:16];
                3'd6: value = ID_TAG[15:8];
                default: value = ID_TAG[7:0];
            endcase
        end
    end

endmodule

// File: rtl/legacy_port_front.sv
module legacy_port_front
    import lgp_pkg::*;
#(
    parameter int          DEPTH       = 1024,
    parameter int          EXEC_CYCLES = 16,
    parameter logic [7:0]  RESP_MASK   = 8'hA5,
    parameter logic [11:0] ID_BASE     = 12'hF00,
    parameter logic [31:0] ID_VERSION  = 32'h0B07_0201,
    parameter logic [31:0] ID_TAG      = 32'h5158_5253
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       port_sel,
    input  logic       bus_wr,
    input  logic       bus_rd,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata
);

    localparam int AW    = $clog2(DEPTH);
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [CNT_W-1:0] LAST_POS = CNT_W'(DEPTH - 1);

    typedef struct packed {
        lgp_state_e       st;
        logic [CNT_W-1:0] len;
        logic [CNT_W-1:0] ptr;
        logic             final_mark;
        logic             idx_arm;
        logic [3:0]       idx_hi;
        logic             idx_rdy;
        logic [11:0]      idx;
        logic             rerr;
    } ctl_t;

    ctl_t q, d;

    // bus decode
    logic wr_data, wr_ctl, rd_data, rd_ctl;
    logic ctl_abort, ctl_final, ctl_index;
    logic idx_load, cmd_wr, cmd_end, exec_done;
    logic [7:0] store_byte, ident_byte, status_byte;

    assign wr_data   = bus_wr && !port_sel;
    assign wr_ctl    = bus_wr && port_sel;
    assign rd_data   = bus_rd && !bus_wr && !port_sel;
    assign rd_ctl    = bus_rd && !bus_wr && port_sel;
    assign ctl_abort = wr_ctl && (bus_wdata == CTL_ABORT);
    assign ctl_final = wr_ctl && (bus_wdata == CTL_FINAL);
    assign ctl_index = wr_ctl && bus_wdata[CTL_INDEX_BIT];
    assign idx_load  = wr_data && q.idx_arm;
    assign cmd_wr    = wr_data && !q.idx_arm &&
                       ((q.st == ST_IDLE) || (q.st == ST_RECV));
    assign cmd_end   = cmd_wr && (q.final_mark || (q.len == LAST_POS));

    always_comb begin
        d = q;

        // indexed register access
        if (ctl_index) begin
            d.idx_arm = 1'b1;
            d.idx_hi  = bus_wdata[3:0];
            d.idx_rdy = 1'b0;
        end
        if (idx_load) begin
            d.idx     = {q.idx_hi, bus_wdata};
            d.idx_arm = 1'b0;
            d.idx_rdy = 1'b1;
        end
        if (rd_ctl && q.idx_rdy) begin
            d.idx_rdy = 1'b0;
        end

        if (ctl_final && ((q.st == ST_IDLE) || (q.st == ST_RECV))) begin
            d.final_mark = 1'b1;
        end

        case (q.st)
            ST_IDLE: begin
                if (cmd_wr) begin
                    d.rerr = 1'b0;
                    d.len  = CNT_W'(1);
                    d.st   = cmd_end ? ST_BUSY : ST_RECV;
                    if (cmd_end) d.final_mark = 1'b0;
                end
            end
            ST_RECV: begin
                if (cmd_wr) begin
                    d.len = q.len + 1'b1;
                    if (cmd_end) begin
                        d.st         = ST_BUSY;
                        d.final_mark = 1'b0;
                    end
                end
            end
            ST_BUSY: begin
                if (exec_done) begin
                    d.st  = ST_RESP;
                    d.ptr = '0;
                end
            end
            default: begin
                if (rd_data) begin
                    d.ptr = q.ptr + 1'b1;
                    if ((q.ptr + 1'b1) == q.len) begin
                        d.st  = ST_IDLE;
                        d.len = '0;
                        d.ptr = '0;
                    end
                end
            end
        endcase

        if (rd_data && (q.st != ST_RESP)) begin
            d.rerr = 1'b1;
        end

        if (ctl_abort) begin
            d.st         = ST_IDLE;
            d.len        = '0;
            d.ptr        = '0;
            d.final_mark = 1'b0;
            d.idx_arm    = 1'b0;
            d.idx_rdy    = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: ST_IDLE, len: '0, ptr: '0, final_mark: 1'b0,
                   idx_arm: 1'b0, idx_hi: '0, idx_rdy: 1'b0, idx: '0,
                   rerr: 1'b0};
        end else begin
            q <= d;
        end
    end

    lgp_cmd_store #(.DEPTH(DEPTH)) u_store (
        .clk     (clk),
        .wr_en   (cmd_wr),
        .wr_addr (q.len[AW-1:0]),
        .wr_byte (bus_wdata),
        .rd_addr (q.ptr[AW-1:0]),
        .rd_byte (store_byte)
    );

    lgp_exec_stub #(.EXEC_CYCLES(EXEC_CYCLES)) u_exec (
        .clk   (clk),
        .rst_n (rst_n),
        .start (cmd_end),
        .abort (ctl_abort),
        .done  (exec_done)
    );

    lgp_ident_rom #(
        .ID_BASE    (ID_BASE),
        .ID_VERSION (ID_VERSION),
        .ID_TAG     (ID_TAG)
    ) u_ident (
        .index (q.idx),
        .value (ident_byte)
    );

    assign status_byte = {5'b0, q.rerr, (q.st == ST_RESP), (q.st == ST_BUSY)};

    always_comb begin
        if (port_sel) begin
            bus_rdata = q.idx_rdy ? ident_byte : status_byte;
        end else if (q.st == ST_RESP) begin
            bus_rdata = store_byte ^ RESP_MASK;
        end else begin
            bus_rdata = EMPTY_BYTE;
        end
    end

    // state views for the bound checker
    lgp_state_e       cur_st;
    logic [CNT_W-1:0] cur_len;
    logic [CNT_W-1:0] cur_ptr;
    logic             cur_rerr;
    assign cur_st   = q.st;
    assign cur_len  = q.len;
    assign cur_ptr  = q.ptr;
    assign cur_rerr = q.rerr;

endmodule

// File: rtl/lgp_checker.sv
module lgp_checker
    import lgp_pkg::*;
#(
    parameter int DEPTH = 1024,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             port_sel,
    input logic             bus_wr,
    input logic             bus_rd,
    input logic [7:0]       bus_wdata,
    input lgp_state_e       cur_st,
    input logic [CNT_W-1:0] cur_len,
    input logic [CNT_W-1:0] cur_ptr,
    input logic             cur_rerr
);

    logic is_abort, is_rd0, is_wr0;
    assign is_abort = bus_wr && port_sel && (bus_wdata == CTL_ABORT);
    assign is_rd0   = bus_rd && !bus_wr && !port_sel;
    assign is_wr0   = bus_wr && !port_sel;

    assert_abort_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        is_abort |=> (cur_st == ST_IDLE) && (cur_len == '0));

    assert_retry_set_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (is_rd0 && (cur_st != ST_RESP)) |=> cur_rerr);

    assert_write_ignored_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (is_wr0 && ((cur_st == ST_BUSY) || (cur_st == ST_RESP))) |=> $stable(cur_len));

    assert_busy_exit_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ((cur_st == ST_BUSY) && !is_abort) |=> ((cur_st == ST_BUSY) || (cur_st == ST_RESP)));

    assert_resp_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((cur_st == ST_RESP) && !is_rd0 && !is_abort) |=> ((cur_st == ST_RESP) && $stable(cur_ptr)));

    assert_len_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cur_len <= CNT_W'(DEPTH));

endmodule

bind legacy_port_front lgp_checker #(.DEPTH(DEPTH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .port_sel  (port_sel),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_wdata (bus_wdata),
    .cur_st    (cur_st),
    .cur_len   (cur_len),
    .cur_ptr   (cur_ptr),
    .cur_rerr  (cur_rerr)
);

// File: tb/sim_legacy_port_front.sv
module sim_legacy_port_front;

    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 1024;
    localparam int EXEC       = 20;
    localparam logic [7:0] MASK = 8'hA5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic port_sel = 1'b0;
    logic bus_wr = 1'b0;
    logic bus_rd = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;

    int total = 0;
    int bad = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    legacy_port_front #(
        .DEPTH       (DEPTH),
        .EXEC_CYCLES (EXEC),
        .RESP_MASK   (MASK),
        .ID_BASE     (12'hF00),
        .ID_VERSION  (32'h0B07_0201),
        .ID_TAG      (32'h5158_5253)
    ) u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .port_sel  (port_sel),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata)
    );

    // {index, expected byte}
    localparam logic [19:0] ID_VEC [10] = '{
        {12'hF00, 8'h01}, {12'hF01, 8'h02}, {12'hF02, 8'h07}, {12'hF03, 8'h0B},
        {12'hF04, 8'h51}, {12'hF05, 8'h58}, {12'hF06, 8'h52}, {12'hF07, 8'h53},
        {12'hF08, 8'hFF}, {12'h000, 8'hFF}
    };

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic sel, input logic [7:0] data);
        @(negedge clk);
        port_sel  = sel;
        bus_wdata = data;
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_wr    = 1'b0;
    endtask

    task automatic bus_read(input logic sel, output logic [7:0] data);
        @(negedge clk);
        port_sel = sel;
        bus_rd   = 1'b1;
        #1 data  = bus_rdata;
        @(negedge clk);
        bus_rd   = 1'b0;
    endtask

    task automatic peek(input logic sel, output logic [7:0] data);
        @(negedge clk);
        port_sel = sel;
        #1 data  = bus_rdata;
    endtask

    // count cycles of busy, starting at the current negedge
    task automatic count_busy(output int n);
        n = 0;
        port_sel = 1'b1;
        #1;
        while (bus_rdata[0] && n < 200) begin
            n++;
            @(negedge clk);
            #1;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [7:0] v;
        int n;
        logic [7:0] cmd [5];
        int mism;

        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1 / R4 reset state
        peek(1'b1, v);
        chk(v, 8'h00, "R1 status after reset");
        peek(1'b0, v);
        chk(v, 8'hFF, "R1 data port after reset");

        // R2 / R3 identity table walk
        foreach (ID_VEC[i]) begin
            bus_write(1'b1, {4'h8, ID_VEC[i][19:16]});
            bus_write(1'b0, ID_VEC[i][15:8]);
            peek(1'b1, v);
            chk(v, ID_VEC[i][7:0], $sformatf("R3 index %0h", ID_VEC[i][19:8]));
            bus_read(1'b1, v);
            peek(1'b1, v);
            chk(v, 8'h00, "R2 status returns after indexed read");
        end

        // R10 retry-error on read with nothing pending
        bus_read(1'b0, v);
        chk(v, 8'hFF, "R10 empty read value");
        peek(1'b1, v);
        chk(v, 8'h04, "R10 R4 retry-error bit");

        // R5 five-byte command with final mark
        cmd = '{8'h10, 8'h22, 8'h3F, 8'hC4, 8'h07};
        for (int i = 0; i < 4; i++) bus_write(1'b0, cmd[i]);
        peek(1'b1, v);
        chk(v, 8'h00, "R10 retry cleared by command start, not busy yet");
        bus_write(1'b1, 8'h04);
        bus_write(1'b0, cmd[4]);
        count_busy(n);
        chk(n, EXEC, "R7 busy duration");
        peek(1'b1, v);
        chk(v, 8'h02, "R4 data-available status");
        // R11 write while data available is ignored
        bus_write(1'b0, 8'h77);
        mism = 0;
        for (int i = 0; i < 5; i++) begin
            bus_read(1'b0, v);
            if (v !== (cmd[i] ^ MASK)) mism++;
        end
        chk(mism, 0, "R8 response bytes");
        peek(1'b1, v);
        chk(v, 8'h00, "R8 R11 data-available cleared after length");

        // R11 write during busy ignored
        bus_write(1'b0, 8'h41);
        bus_write(1'b1, 8'h04);
        bus_write(1'b0, 8'h42);
        bus_write(1'b0, 8'h99);
        count_busy(n);
        bus_read(1'b0, v);
        chk(v, 8'h41 ^ MASK, "R11 first response byte");
        bus_read(1'b0, v);
        chk(v, 8'h42 ^ MASK, "R11 second response byte");
        peek(1'b1, v);
        chk(v, 8'h00, "R11 response length unchanged by busy write");

        // R9 abort while receiving
        bus_write(1'b0, 8'hAA);
        bus_write(1'b0, 8'hBB);
        bus_write(1'b1, 8'h01);
        peek(1'b1, v);
        chk(v, 8'h00, "R9 abort during receive");
        bus_write(1'b1, 8'h04);
        bus_write(1'b0, 8'h3C);
        count_busy(n);
        bus_read(1'b0, v);
        chk(v, 8'h3C ^ MASK, "R9 new command after abort");
        peek(1'b1, v);
        chk(v, 8'h00, "R9 no stale bytes after abort");

        // R9 abort while busy
        bus_write(1'b1, 8'h04);
        bus_write(1'b0, 8'h55);
        bus_write(1'b1, 8'h01);
        repeat (EXEC + 5) @(negedge clk);
        peek(1'b1, v);
        chk(v, 8'h00, "R9 abort during busy stays idle");

        // R9 abort while response pending
        bus_write(1'b1, 8'h04);
        bus_write(1'b0, 8'h66);
        count_busy(n);
        bus_write(1'b1, 8'h01);
        peek(1'b1, v);
        chk(v, 8'h00, "R9 abort during response");
        peek(1'b0, v);
        chk(v, 8'hFF, "R9 data port empty after abort");

        // R6 full-depth command ends without mark
        for (int i = 0; i < DEPTH - 1; i++) bus_write(1'b0, 8'(i) ^ 8'h5A);
        peek(1'b1, v);
        chk(v, 8'h00, "R6 not busy before last byte");
        bus_write(1'b0, 8'(DEPTH - 1) ^ 8'h5A);
        peek(1'b1, v);
        chk(v, 8'h01, "R6 busy after full-depth byte");
        count_busy(n);
        mism = 0;
        for (int i = 0; i < DEPTH; i++) begin
            bus_read(1'b0, v);
            if (v !== ((8'(i) ^ 8'h5A) ^ MASK)) mism++;
        end
        chk(mism, 0, "R6 R8 full-depth response");
        peek(1'b1, v);
        chk(v, 8'h00, "R6 idle after full response");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule